// File: doc/BRIEF.md
# Three-Channel Interval Timer

This block holds three 16-bit down-counters behind one byte-wide register port. Each counter has its own reload latch and its own interrupt flag. When a counter passes zero on an enabled tick, it reloads from its latch on its own and sets its flag. Software reads the flags from a status byte and clears a flag with a read sequence. A single `irq` output combines the flags of the channels whose interrupt enable is set.

Channels one and three count on an external one-cycle tick pulse. Channel two counts on the same pulse by default. Channel two can also count the expiries of channel three, so the pair forms one 32-bit down-counter. Two control registers sit behind one write address, and a bit in the second control register chooses which of them that address updates. A reset bit in the first control register holds every counter at its latch value.

Each channel runs a small two-state clear machine. In `ARM_IDLE` the channel waits. The transition *arm* moves it to `ARM_SET` when the status byte is read while its flag is set. In `ARM_SET`, the transition *clear* (a read of the channel's count high byte) clears the flag and returns to `ARM_IDLE`. The transition *drop* (the flag is already low, or the counters are held) returns to `ARM_IDLE` without a clear.

Top module: `tri_interval_timer`

## Requirements
- R1: A counter holding N, outside hold, sets its flag on the N+1-th tick it receives after release. Each tick before that lowers the count by one.
- R2: On that expiring tick the counter reloads its latch value and keeps counting. With no software action the next expiry comes N+1 ticks later.
- R3: The status byte at offset 1 carries the channel flags: bit 0 for channel 1, bit 1 for channel 2, bit 2 for channel 3. Bit 7 is high whenever any flag is set. The other bits read 0.
- R4: A flag is cleared only by a read of that channel's count high byte that follows a status read taken while the flag was set. A count read with no such status read, or a read of another channel's count, leaves the flag set.
- R5: When bit 1 of control register 2 is set, channel 2 counts expiries of channel 3 and first expires after (N2+1)*(N3+1) ticks. When that bit is clear, channel 2 counts ticks directly.
- R6: Writes to offset 1 update control register 1 when bit 0 of control register 2 is 1, and control register 3 when it is 0. Control register 2 is written at offset 3.
- R7: While bit 0 of control register 1 is set, every counter follows its latch, every flag is clear and ticks have no effect. After `rst_n` that bit is set, `irq` is 0, the status byte is 0 and every count reads 0xFFFF.
- R8: A write to a latch high byte (offsets 5, 9, 13 for channels 1, 2, 3) is only buffered. The 16-bit latch changes when the low byte is written (offsets 7, 11, 15). The same offsets read the live count, high byte and low byte.
- R9: `irq` is the OR over channels of flag AND enable, where bit 6 of control registers 1, 2 and 3 enables channels 1, 2 and 3. Clearing an enable drops `irq` but leaves the flag set.
- R10: Outside hold, a counter changes only on cycles with a tick (for channel 2 in cascade, a channel 3 expiry).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_en | input | 1 | One-cycle count pulse for the tick-clocked channels |
| addr | input | 4 | Register offset |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe; its side effects take place at the clock edge |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, combinational from `addr` |
| irq | output | 1 | Combined enabled interrupt |

## Verification
The bench builds the block with its default byte width of 8, which gives 16-bit counts. Small latch values bring expiry within a few ticks, so the bench sweeps every value from 0 to 6 on channels 1 and 3. It also sweeps every pairing of 0 to 2 for the cascaded pair, against the arithmetic N+1 and (N2+1)*(N3+1) tick counts. The clear sequence, the shared control address and the high-byte buffering are each driven through their accepted and their ignored cases.

// File: rtl/tit_pkg.sv
package tit_pkg;
    localparam int NCH          = 3;
    localparam int CTL_HOLD_BIT = 0;   // control 1: hold all counters
    localparam int CTL_SEL_BIT  = 0;   // control 2: 1 selects control 1 at offset 1
    localparam int CTL_CASC_BIT = 1;   // control 2: channel 2 counts channel 3 expiries
    localparam int CTL_IE_BIT   = 6;   // every control register: channel interrupt enable
    localparam int STAT_ANY_BIT = 7;

    typedef enum logic {
        ARM_IDLE = 1'b0,
        ARM_SET  = 1'b1
    } arm_state_e;
endpackage

// File: rtl/tit_decode.sv
module tit_decode
    import tit_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] ctl1,
    output logic [DATA_W-1:0] ctl2,
    output logic [DATA_W-1:0] ctl3,
    output logic [NCH-1:0]    wr_hi,
    output logic [NCH-1:0]    wr_lo,
    output logic [NCH-1:0]    cnt_rd,
    output logic              stat_rd
);
    localparam logic [3:0] OFS_CTL13 = 4'd1;
    localparam logic [3:0] OFS_CTL2  = 4'd3;

    assign stat_rd = rd_en && (addr == OFS_CTL13);

    for (genvar i = 0; i < NCH; i++) begin : g_slot
        localparam logic [1:0] SLOT = 2'(i + 1);
        logic hit;
        assign hit       = addr[0] && (addr[3:2] == SLOT);
        assign wr_hi[i]  = wr_en && hit && !addr[1];
        assign wr_lo[i]  = wr_en && hit &&  addr[1];
        assign cnt_rd[i] = rd_en && hit && !addr[1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl1 <= DATA_W'(1) << CTL_HOLD_BIT;
            ctl2 <= '0;
            ctl3 <= '0;
        end else if (wr_en) begin
            if (addr == OFS_CTL2) begin
                ctl2 <= wdata;
            end else if (addr == OFS_CTL13) begin
                if (ctl2[CTL_SEL_BIT]) ctl1 <= wdata;
                else                   ctl3 <= wdata;
            end
        end
    end

    // R6: offset 1 writes land in exactly one of control 1 / control 3
    p_ctl_select_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && addr == OFS_CTL13 && !ctl2[CTL_SEL_BIT]) |=> $stable(ctl1));
endmodule

// File: rtl/tit_chan.sv
module tit_chan
    import tit_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                hold,
    input  logic                tick,
    input  logic                wr_hi,
    input  logic                wr_lo,
    input  logic [DATA_W-1:0]   wdata,
    input  logic                stat_rd,
    input  logic                cnt_rd,
    output logic [2*DATA_W-1:0] cnt_o,
    output logic                flag_o
);
    localparam int CNT_W = 2 * DATA_W;
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [DATA_W-1:0] hi_buf;
    logic [CNT_W-1:0]  latch_q, cnt_q;
    logic              flag_q, expire, clr_ok;
    arm_state_e        st_q, st_d;

    assign expire = !hold && tick && (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_buf  <= '1;
            latch_q <= '1;
        end else begin
            if (wr_hi) hi_buf <= wdata;
            if (wr_lo) latch_q <= {hi_buf, wdata};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt_q <= '1;
        else if (hold)    cnt_q <= latch_q;
        else if (expire)  cnt_q <= latch_q;
        else if (tick)    cnt_q <= cnt_q - ONE;
    end

    // clear machine: state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ARM_IDLE;
        else        st_q <= st_d;
    end

    // clear machine: next state (arm / clear / drop)
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ARM_IDLE: if (!hold && stat_rd && flag_q) st_d = ARM_SET;
            ARM_SET:  if (hold || !flag_q || cnt_rd)  st_d = ARM_IDLE;
            default:  st_d = ARM_IDLE;
        endcase
    end

    // clear machine: outputs
    always_comb begin
        clr_ok = (st_q == ARM_SET) && cnt_rd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      flag_q <= 1'b0;
        else if (hold)   flag_q <= 1'b0;
        else if (expire) flag_q <= 1'b1;
        else if (clr_ok) flag_q <= 1'b0;
    end

    assign cnt_o  = cnt_q;
    assign flag_o = flag_q;

    p_dec_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && tick && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - ONE));
    p_reload_r2: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> (flag_q && cnt_q == $past(latch_q)));
    p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ARM_SET && cnt_rd && !expire) |=> !flag_q);
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hold |=> !flag_q);
    p_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!hold && !tick) |=> $stable(cnt_q));
endmodule

// File: rtl/tri_interval_timer.sv
module tri_interval_timer
    import tit_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic [3:0]        addr,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);
    localparam int CNT_W = 2 * DATA_W;

    logic [DATA_W-1:0] ctl1, ctl2, ctl3, status;
    logic [NCH-1:0]    wr_hi, wr_lo, cnt_rd, flags, ie, tick_v;
    logic              stat_rd, hold, casc_tick;
    logic [CNT_W-1:0]  cnt_a [NCH];

    tit_decode #(.DATA_W(DATA_W)) u_dec (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .ctl1(ctl1), .ctl2(ctl2), .ctl3(ctl3),
        .wr_hi(wr_hi), .wr_lo(wr_lo), .cnt_rd(cnt_rd), .stat_rd(stat_rd)
    );

    assign hold      = ctl1[CTL_HOLD_BIT];
    assign casc_tick = tick_en && !hold && (cnt_a[2] == '0);
    assign tick_v    = {tick_en, (ctl2[CTL_CASC_BIT] ? casc_tick : tick_en), tick_en};
    assign ie        = {ctl3[CTL_IE_BIT], ctl2[CTL_IE_BIT], ctl1[CTL_IE_BIT]};

    for (genvar i = 0; i < NCH; i++) begin : g_ch
        tit_chan #(.DATA_W(DATA_W)) u_ch (
            .clk(clk), .rst_n(rst_n), .hold(hold), .tick(tick_v[i]),
            .wr_hi(wr_hi[i]), .wr_lo(wr_lo[i]), .wdata(wdata),
            .stat_rd(stat_rd), .cnt_rd(cnt_rd[i]),
            .cnt_o(cnt_a[i]), .flag_o(flags[i])
        );
    end

    always_comb begin
        status = '0;
        status[NCH-1:0]     = flags;
        status[STAT_ANY_BIT] = |flags;
    end

    assign irq = |(flags & ie);

    always_comb begin
        rdata = '0;
        if (addr == 4'd1) begin
            rdata = status;
        end else if (addr[0] && addr[3:2] != 2'd0) begin
            rdata = addr[1] ? cnt_a[addr[3:2] - 2'd1][DATA_W-1:0]
                            : cnt_a[addr[3:2] - 2'd1][CNT_W-1:DATA_W];
        end
    end

    p_irq_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (|flags));
    p_casc_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl2[CTL_CASC_BIT] && !hold && tick_en && cnt_a[2] == '0 && cnt_a[1] != '0)
        |=> (cnt_a[1] == $past(cnt_a[1]) - CNT_W'(1)));
endmodule

// File: tb/sim_tri_interval_timer.sv
module sim_tri_interval_timer;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic [3:0] addr = '0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       irq;
    int tests = 0;
    int fails = 0;

    always #10 clk = ~clk;

    tri_interval_timer u0 (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .addr(addr),
        .wr_en(wr_en), .rd_en(rd_en), .wdata(wdata), .rdata(rdata), .irq(irq)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=0x%0h exp=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk); addr = a; rd_en = 1'b1; #1 d = rdata;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic peek(input logic [3:0] a, output logic [7:0] d);
        addr = a; #1 d = rdata;
    endtask

    task automatic peek16(input int ch, output logic [15:0] v);
        logic [7:0] h, l;
        peek(4'(4*ch + 5), h);
        peek(4'(4*ch + 7), l);
        v = {h, l};
    endtask

    task automatic tick1();
        @(negedge clk); tick_en = 1'b1;
        @(negedge clk); tick_en = 1'b0;
    endtask

    task automatic load(input int ch, input logic [15:0] v);
        wr(4'(4*ch + 5), v[15:8]);
        wr(4'(4*ch + 7), v[7:0]);
    endtask

    // hold, load latches, enable all interrupts, release
    task automatic setup(input bit casc, input logic [15:0] l1, input logic [15:0] l2,
                         input logic [15:0] l3);
        logic [7:0] c2;
        c2 = {6'b0, casc, 1'b0};
        wr(4'd3, c2 | 8'h01);
        wr(4'd1, 8'h01);
        load(0, l1); load(1, l2); load(2, l3);
        wr(4'd3, c2);
        wr(4'd1, 8'h40);
        wr(4'd3, c2 | 8'h41);
        wr(4'd1, 8'h40);
    endtask

    task automatic run_until(input int bitn, input int lim, output int first);
        logic [7:0] s;
        first = 0;
        for (int k = 1; k <= lim; k++) begin
            tick1();
            peek(4'd1, s);
            if (s[bitn]) begin
                first = k;
                break;
            end
        end
    endtask

    initial begin
        #(20 * 100000);
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [7:0]  s, x;
        logic [15:0] v;
        int          first;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R7: reset state
        peek(4'd1, s);
        chk(s == 8'h00, "R7 status after reset", s, 0);
        chk(irq == 1'b0, "R7 irq after reset", irq, 0);
        peek16(0, v);
        chk(v == 16'hFFFF, "R7 count after reset", v, 16'hFFFF);

        // R8: high byte buffered until low byte
        wr(4'd5, 8'h12);
        @(negedge clk);
        peek16(0, v);
        chk(v == 16'hFFFF, "R8 high byte alone", v, 16'hFFFF);
        wr(4'd7, 8'h34);
        @(negedge clk);
        peek16(0, v);
        chk(v == 16'h1234, "R8 latch after low byte", v, 16'h1234);

        // R7: ticks ignored while held
        repeat (4) tick1();
        peek16(0, v);
        chk(v == 16'h1234, "R7 held count", v, 16'h1234);
        peek(4'd1, s);
        chk(s == 8'h00, "R7 held flags", s, 0);

        // R1, R2, R3, R4: channel 1 sweep
        for (int n = 0; n <= 6; n++) begin
            setup(1'b0, 16'(n), 16'hFFFF, 16'hFFFF);
            run_until(0, n + 3, first);
            chk(first == n + 1, "R1 ch1 expiry tick", first, n + 1);
            peek(4'd1, s);
            chk(s == 8'h81, "R3 ch1 status byte", s, 8'h81);
            peek16(0, v);
            chk(v == 16'(n), "R2 reload value", v, n);
            rd(4'd1, s);
            rd(4'd5, x);
            peek(4'd1, s);
            chk(s[0] == 1'b0, "R4 ch1 flag cleared", s, 0);
            run_until(0, n + 3, first);
            chk(first == n + 1, "R2 second expiry", first, n + 1);
        end

        // R1, R3: channel 3 sweep
        for (int n = 0; n <= 6; n++) begin
            setup(1'b0, 16'hFFFF, 16'hFFFF, 16'(n));
            run_until(2, n + 3, first);
            chk(first == n + 1, "R1 ch3 expiry tick", first, n + 1);
            peek(4'd1, s);
            chk(s == 8'h84, "R3 ch3 status byte", s, 8'h84);
        end

        // R4: reads that must not clear
        rd(4'd13, x);
        peek(4'd1, s);
        chk(s[2] == 1'b1, "R4 count read without status read", s, 8'h84);
        rd(4'd1, s);
        rd(4'd9, x);
        peek(4'd1, s);
        chk(s[2] == 1'b1, "R4 other channel count read", s, 8'h84);
        rd(4'd13, x);
        peek(4'd1, s);
        chk(s[2] == 1'b0, "R4 proper sequence clears", s, 0);

        // R9: irq and enable
        setup(1'b0, 16'd3, 16'hFFFF, 16'hFFFF);
        run_until(0, 6, first);
        chk(irq == 1'b1, "R9 irq with enable", irq, 1);
        wr(4'd1, 8'h00);
        chk(irq == 1'b0, "R9 irq with enable cleared", irq, 0);
        peek(4'd1, s);
        chk(s == 8'h81, "R9 flag kept without enable", s, 8'h81);

        // R10: no tick, no change
        setup(1'b0, 16'd10, 16'hFFFF, 16'hFFFF);
        repeat (6) @(negedge clk);
        peek16(0, v);
        chk(v == 16'd10, "R10 idle count", v, 10);
        repeat (3) tick1();
        peek16(0, v);
        chk(v == 16'd7, "R10 three ticks", v, 7);

        // R5: cascade sweep
        for (int a = 0; a <= 2; a++) begin
            for (int b = 0; b <= 2; b++) begin
                setup(1'b1, 16'hFFFF, 16'(a), 16'(b));
                run_until(1, (a + 1) * (b + 1) + 2, first);
                chk(first == (a + 1) * (b + 1), "R5 cascade expiry", first, (a + 1) * (b + 1));
            end
        end
        setup(1'b0, 16'hFFFF, 16'd4, 16'hFFFF);
        run_until(1, 7, first);
        chk(first == 5, "R5 ch2 on tick without cascade", first, 5);

        // R6: shared control address
        setup(1'b0, 16'd100, 16'hFFFF, 16'hFFFF);
        wr(4'd3, 8'h40);
        wr(4'd1, 8'h01);
        tick1(); tick1();
        peek16(0, v);
        chk(v == 16'd98, "R6 write went to control 3", v, 98);
        wr(4'd3, 8'h41);
        wr(4'd1, 8'h01);
        @(negedge clk);
        peek16(0, v);
        chk(v == 16'd100, "R6 write went to control 1", v, 100);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule